// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block loads a bitstream into an SRAM-based programmable target over a passive serial link. A start pulse makes it pull the target's active-low program pin low for a set number of cycles and then release it. It then waits for the target's status line to come high, with a time limit. After that it takes configuration bytes from a valid/ready stream and shifts each byte out on a serial data line, least significant bit first, one bit per serial clock pulse.

The serial clock half-period is a fixed number of system clock cycles. Data changes only while the serial clock is low, so it is stable at every rising edge. When the stream has no byte ready, the serial clock stops low. When the target reports that loading is complete, the host sends exactly two more clock pulses. It then waits for the target's init-done line, if that option is enabled, and reports done. The host reports an error with a code in four cases: the status line stays low after release, the status line drops during loading, a set byte count has been sent with no completion, or init-done never arrives. Another start pulse clears the error and begins a new attempt.

Top module: `pscfg_host`

## Requirements
- R1: After synchronous reset, prog_n is 1, ser_clk is 0, in_ready is 0, and busy, done, error and err_code are all 0.
- R2: A start pulse in the idle, user or error state drives prog_n low for exactly RST_CYCLES system clock cycles, and then drives it high again.
- R3: ser_clk makes no rising edge before the synchronized tgt_status has been seen high. If tgt_status does not rise within STATUS_TIMEOUT cycles after prog_n is released, error is set with err_code 1.
- R4: Each accepted byte appears on ser_dat bit 0 first, one bit per ser_clk rising edge. ser_dat never changes in the cycle where ser_clk rises. Each ser_clk high phase lasts exactly CLK_DIV cycles.
- R5: If no byte is offered after the current byte has been shifted out, ser_clk stays low and makes no edge until a new byte is accepted.
- R6: Once tgt_loaded is seen high, ser_clk makes exactly two more rising-and-falling pulses and then stays low.
- R7: With USE_INIT_DONE set, done rises only after tgt_ready is high, and busy stays high until then. If tgt_ready does not rise within INIT_TIMEOUT cycles, error is set with err_code 4.
- R8: If tgt_status goes low while loading, the host aborts. It sets error with err_code 2, parks ser_clk low, drops in_ready and keeps prog_n high.
- R9: After MAX_BYTES bytes have been accepted without tgt_loaded, no further byte is accepted. If tgt_loaded is still low DONE_WAIT cycles later, error is set with err_code 3.
- R10: A start pulse from the error state clears error and err_code in the next cycle, together with the prog_n low pulse.
- R11: In the user state, in_ready stays 0, stream input is ignored and ser_clk makes no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin (re)configuration |
| in_data | input | BYTE_W | Configuration byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Host takes the byte this cycle when in_valid is high |
| prog_n | output | 1 | Active-low program request to the target |
| ser_clk | output | 1 | Serial configuration clock |
| ser_dat | output | 1 | Serial configuration data |
| tgt_status | input | 1 | Target status, high when ready or healthy (asynchronous) |
| tgt_loaded | input | 1 | Target reports the whole bitstream received (asynchronous) |
| tgt_ready | input | 1 | Target has finished initialization (asynchronous) |
| busy | output | 1 | Configuration in progress |
| done | output | 1 | Target is in user mode |
| error | output | 1 | Attempt failed |
| err_code | output | 3 | 0 none, 1 status timeout, 2 status lost, 3 completion timeout, 4 init timeout |

## Verification
The bench builds the host with CLK_DIV=2, RST_CYCLES=8, STATUS_TIMEOUT=64, MAX_BYTES=12, DONE_WAIT=32 and INIT_TIMEOUT=48, with the init-done wait enabled. With these small limits, every timeout path is reached in a few hundred cycles. The byte limit is hit after a dozen bytes, so sending one extra byte exercises the refusal. A target model in the bench rebuilds each byte from the serial edges and counts the trailing pulses. It can delay, withhold or drop its status, completion and init lines on command.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESET_PULSE,
    ST_WAIT_STATUS,
    ST_SHIFT,
    ST_WAIT_DONE,
    ST_EXTRA_CLOCKS,
    ST_WAIT_INIT,
    ST_USER,
    ST_ERROR
  } pscfg_state_e;

  typedef enum logic [2:0] {
    ERR_NONE           = 3'd0,
    ERR_STATUS_TIMEOUT = 3'd1,
    ERR_STATUS_LOST    = 3'd2,
    ERR_DONE_TIMEOUT   = 3'd3,
    ERR_INIT_TIMEOUT   = 3'd4
  } pscfg_err_e;

  function automatic int pscfg_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pscfg_halfdiv.sv
module pscfg_halfdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  if (DIV > 1) begin : g_count
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst || !en)                   cnt_q <= '0;
      else if (cnt_q == CW'(DIV - 1))   cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
    end
    assign tick = en && (cnt_q == CW'(DIV - 1));

    // R4: a half period never collapses to one cycle
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end else begin : g_pass
    assign tick = en;
  end
endmodule

// File: rtl/pscfg_timer.sv
module pscfg_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)           cnt_q <= '0;
    else if (cnt_q != limit)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == limit);

  // R3: once reached, the limit holds until the timer is restarted
  a_r3_timer_saturates: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr && $stable(limit)) |=> expired);
endmodule

// File: rtl/pscfg_host.sv
module pscfg_host
  import pscfg_pkg::*;
#(
  parameter int CLK_DIV        = 4,
  parameter int BYTE_W         = 8,
  parameter int RST_CYCLES     = 32,
  parameter int STATUS_TIMEOUT = 4096,
  parameter int MAX_BYTES      = 1048576,
  parameter int DONE_WAIT      = 256,
  parameter int INIT_TIMEOUT   = 4096,
  parameter int USE_INIT_DONE  = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              prog_n,
  output logic              ser_clk,
  output logic              ser_dat,
  input  logic              tgt_status,
  input  logic              tgt_loaded,
  input  logic              tgt_ready,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [2:0]        err_code
);
  localparam int BC_W    = $clog2(MAX_BYTES + 1);
  localparam int BIT_W   = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int TMR_MAX = pscfg_max(pscfg_max(RST_CYCLES, STATUS_TIMEOUT),
                                     pscfg_max(DONE_WAIT, INIT_TIMEOUT));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  pscfg_state_e state_q, state_d;
  pscfg_err_e   err_q, err_d;

  logic [2:0] pins_s;
  logic       nstat_s, cdone_s, init_s;

  logic [BYTE_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BC_W-1:0]   byte_cnt_q;
  logic              have_q, dclk_q, data0_q, ncfg_q, pulse_q;
  logic              busy_q, done_q, error_q;

  logic              tmr_clr, tmr_exp;
  logic [TMR_W-1:0]  tmr_limit;
  logic              div_en, div_tick;
  logic              at_limit, accept, idle_like;

  // ---------------- input synchronizers ----------------
  pscfg_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({tgt_ready, tgt_loaded, tgt_status}),
    .sync_out (pins_s)
  );
  assign nstat_s = pins_s[0];
  assign cdone_s = pins_s[1];
  assign init_s  = pins_s[2];

  // ---------------- state timer ----------------
  always_comb begin
    case (state_q)
      ST_RESET_PULSE: tmr_limit = TMR_W'(RST_CYCLES - 1);
      ST_WAIT_STATUS: tmr_limit = TMR_W'(STATUS_TIMEOUT);
      ST_WAIT_DONE:   tmr_limit = TMR_W'(DONE_WAIT);
      ST_WAIT_INIT:   tmr_limit = TMR_W'(INIT_TIMEOUT);
      default:        tmr_limit = '0;
    endcase
  end
  assign tmr_clr = (state_q != state_d);

  pscfg_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .limit   (tmr_limit),
    .expired (tmr_exp)
  );

  // ---------------- serial clock divider ----------------
  assign div_en = ((state_q == ST_SHIFT) && (dclk_q || have_q)) ||
                  (state_q == ST_EXTRA_CLOCKS);

  pscfg_halfdiv #(.DIV(CLK_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (div_en),
    .tick (div_tick)
  );

  // ---------------- stream handshake ----------------
  assign at_limit = (byte_cnt_q == BC_W'(MAX_BYTES));
  assign in_ready = (state_q == ST_SHIFT) && !have_q && !dclk_q &&
                    nstat_s && !cdone_s && !at_limit;
  assign accept   = in_valid && in_ready;
  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_USER) ||
                     (state_q == ST_ERROR);

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    case (state_q)
      ST_RESET_PULSE:
        if (tmr_exp) state_d = ST_WAIT_STATUS;
      ST_WAIT_STATUS:
        if (nstat_s) state_d = ST_SHIFT;
        else if (tmr_exp) begin
          state_d = ST_ERROR;
          err_d   = ERR_STATUS_TIMEOUT;
        end
      ST_SHIFT:
        if (!nstat_s) begin
          state_d = ST_ERROR;
          err_d   = ERR_STATUS_LOST;
        end else if (!have_q && !dclk_q) begin
          if (cdone_s)       state_d = ST_EXTRA_CLOCKS;
          else if (at_limit) state_d = ST_WAIT_DONE;
        end
      ST_WAIT_DONE:
        if (!nstat_s) begin
          state_d = ST_ERROR;
          err_d   = ERR_STATUS_LOST;
        end else if (cdone_s) state_d = ST_EXTRA_CLOCKS;
        else if (tmr_exp) begin
          state_d = ST_ERROR;
          err_d   = ERR_DONE_TIMEOUT;
        end
      ST_EXTRA_CLOCKS:
        if (!nstat_s) begin
          state_d = ST_ERROR;
          err_d   = ERR_STATUS_LOST;
        end else if (div_tick && dclk_q && pulse_q) begin
          state_d = (USE_INIT_DONE != 0) ? ST_WAIT_INIT : ST_USER;
        end
      ST_WAIT_INIT:
        if (init_s) state_d = ST_USER;
        else if (tmr_exp) begin
          state_d = ST_ERROR;
          err_d   = ERR_INIT_TIMEOUT;
        end
      default:
        if (idle_like && start) begin
          state_d = ST_RESET_PULSE;
          err_d   = ERR_NONE;
        end
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      err_q      <= ERR_NONE;
      ncfg_q     <= 1'b1;
      dclk_q     <= 1'b0;
      data0_q    <= 1'b0;
      sh_q       <= '0;
      bit_q      <= '0;
      have_q     <= 1'b0;
      byte_cnt_q <= '0;
      pulse_q    <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      error_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      ncfg_q  <= (state_d != ST_RESET_PULSE);
      busy_q  <= !((state_d == ST_IDLE) || (state_d == ST_USER) ||
                   (state_d == ST_ERROR));
      done_q  <= (state_d == ST_USER);
      error_q <= (state_d == ST_ERROR);

      if (state_d == ST_RESET_PULSE) begin
        dclk_q     <= 1'b0;
        data0_q    <= 1'b0;
        bit_q      <= '0;
        have_q     <= 1'b0;
        byte_cnt_q <= '0;
        pulse_q    <= 1'b0;
      end else if (state_d == ST_ERROR) begin
        dclk_q <= 1'b0;
        have_q <= 1'b0;
      end else if (state_q == ST_SHIFT) begin
        if (accept) begin
          sh_q    <= in_data;
          data0_q <= in_data[0];
          bit_q   <= '0;
          have_q  <= 1'b1;
        end else if (div_tick) begin
          if (dclk_q) begin
            dclk_q <= 1'b0;
            if (bit_q == BIT_W'(BYTE_W - 1)) begin
              have_q     <= 1'b0;
              byte_cnt_q <= byte_cnt_q + 1'b1;
            end else begin
              sh_q    <= sh_q >> 1;
              data0_q <= sh_q[1];
              bit_q   <= bit_q + 1'b1;
            end
          end else begin
            dclk_q <= 1'b1;
          end
        end
      end else if ((state_q == ST_EXTRA_CLOCKS) && div_tick) begin
        dclk_q <= !dclk_q;
        if (dclk_q) pulse_q <= 1'b1;
      end
    end
  end

  assign prog_n   = ncfg_q;
  assign ser_clk  = dclk_q;
  assign ser_dat  = data0_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign error    = error_q;
  assign err_code = err_q;

  // ---------------- assertions ----------------
  // R2: program pin is released only into the status wait
  a_r2_release_to_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(ncfg_q) |-> (state_q == ST_WAIT_STATUS));

  // R3: every rising serial edge follows a seen-high status line
  a_r3_clock_after_status: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk_q) |-> $past(nstat_s));

  // R4: data is stable across the rising serial edge
  a_r4_data_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk_q) |-> $stable(data0_q));

  // R5: an empty stream freezes the serial clock low
  a_r5_pause_when_empty: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SHIFT) && !have_q && !dclk_q && !in_valid) |=> !dclk_q);

  // R6: trailing pulses leave data untouched
  a_r6_data_held_in_trailer: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXTRA_CLOCKS) |-> $stable(data0_q));

  // R8: losing status during loading aborts with the right code
  a_r8_status_lost_aborts: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SHIFT) && !nstat_s) |=> (error_q && !dclk_q &&
                                            (err_q == ERR_STATUS_LOST)));

  // R11: user mode keeps the link quiet
  a_r11_user_quiet: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!dclk_q && !in_ready && ncfg_q));
endmodule

// File: tb/pscfg_host_tb_top.sv
`timescale 1ns/1ps
module pscfg_host_tb_top;
  localparam int CLK_DIV = 2;
  localparam int RST_CYC = 8;
  localparam int ST_TO   = 64;
  localparam int MAXB    = 12;
  localparam int DWAIT   = 32;
  localparam int INIT_TO = 48;
  localparam int NVEC    = 10;
  // {gap cycles after the byte, byte}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h00A5, 16'h0001, 16'h0080, 16'h40FF, 16'h0000,
    16'h003C, 16'h4096, 16'h005A, 16'h007E, 16'h00C3};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, prog_n, ser_clk, ser_dat, busy, done, error;
  logic [2:0] err_code;
  logic dev_st = 1'b1, dev_cd = 1'b1, dev_in = 1'b1;

  always #2.5 clk = ~clk;

  pscfg_host #(
    .CLK_DIV(CLK_DIV), .BYTE_W(8), .RST_CYCLES(RST_CYC), .STATUS_TIMEOUT(ST_TO),
    .MAX_BYTES(MAXB), .DONE_WAIT(DWAIT), .INIT_TIMEOUT(INIT_TO),
    .USE_INIT_DONE(1), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .prog_n(prog_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .tgt_status(dev_st), .tgt_loaded(dev_cd), .tgt_ready(dev_in),
    .busy(busy), .done(done), .error(error), .err_code(err_code)
  );

  int n_chk = 0, n_err = 0, cyc = 0;

  // ---------------- target model ----------------
  int st_delay = 10, total = NVEC, init_delay = 20, drop = -1;
  int bits = 0, stcnt = 0, rises = 0, early = 0, post_rises = 0, initcnt = 0;
  bit released = 1'b0;
  logic clk_prev = 1'b0;
  logic [7:0] rx [16];

  always @(posedge clk) begin
    if (rst) begin
      dev_st <= 1'b1; dev_cd <= 1'b1; dev_in <= 1'b1;
    end else if (prog_n === 1'b0) begin
      dev_st <= 1'b0; dev_cd <= 1'b0; dev_in <= 1'b0;
      bits = 0; stcnt = 0; released = 1'b0; post_rises = 0; initcnt = 0;
      for (int k = 0; k < 16; k++) rx[k] = 8'h00;
    end else begin
      if (!released && st_delay >= 0) begin
        stcnt++;
        if (stcnt >= st_delay) begin dev_st <= 1'b1; released = 1'b1; end
      end
      if (ser_clk && !clk_prev) begin
        rises++;
        if (!dev_st) early++;
        if (!dev_cd) begin
          if (bits < 128) rx[bits/8][bits%8] = ser_dat;
          bits++;
          if (bits == total*8) dev_cd <= 1'b1;
          if (drop >= 0 && bits == drop*8) dev_st <= 1'b0;
        end else post_rises++;
      end
      if (post_rises >= 2 && !ser_clk && init_delay >= 0) begin
        initcnt++;
        if (initcnt >= init_delay) dev_in <= 1'b1;
      end
    end
    clk_prev <= ser_clk;
  end

  // ---------------- pin monitors ----------------
  int low_run = 0, last_low = 0, hi_run = 0, hi_min = 999, hi_max = 0;
  always @(negedge clk) begin
    if (prog_n === 1'b0) low_run++;
    else if (low_run != 0) begin last_low = low_run; low_run = 0; end
    if (ser_clk === 1'b1) hi_run++;
    else if (hi_run != 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ok);
    int w = 0;
    in_data = b; in_valid = 1'b1;
    while (!in_ready && w < 400) begin @(negedge clk); w++; end
    ok = in_ready;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_end(input int maxc);
    int w = 0;
    while (!(done || error) && w < maxc) begin @(negedge clk); w++; end
  endtask

  initial begin
    bit ok;
    int snap;
    // ---- R1: reset state ----
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "prog_n", prog_n, 1);
    chk("R1", "ser_clk", ser_clk, 0);
    chk("R1", "in_ready", in_ready, 0);
    chk("R1", "busy/done/error/code", {busy, done, error, err_code}, 0);

    // ---- nominal load: vector table walk ----
    st_delay = 10; total = NVEC; init_delay = 20; drop = -1;
    hi_min = 999; hi_max = 0;
    pulse_start();
    chk("R2", "prog_n low after start", prog_n, 0);
    for (int i = 0; i < NVEC; i++) begin
      send_byte(VEC[i][7:0], ok);
      chk("R4", "byte accepted", ok, 1);
      if (VEC[i][15:8] != 0) begin
        repeat (40) @(negedge clk);
        snap = rises;
        repeat (int'(VEC[i][15:8]) - 40) @(negedge clk);
        chk("R5", "no edge while stream empty", rises, snap);
        chk("R5", "ser_clk parked low", ser_clk, 0);
      end
    end
    for (int w = 0; w < 500 && post_rises < 2; w++) @(negedge clk);
    @(negedge clk);
    chk("R7", "done before init-done", done, 0);
    chk("R7", "busy before init-done", busy, 1);
    wait_end(500);
    chk("R7", "done after init-done", done, 1);
    chk("R7", "no error", error, 0);
    chk("R2", "prog_n low length", last_low, RST_CYC);
    chk("R3", "edges before status", early, 0);
    chk("R4", "high time min", hi_min, CLK_DIV);
    chk("R4", "high time max", hi_max, CLK_DIV);
    for (int i = 0; i < NVEC; i++)
      chk("R4", $sformatf("received byte %0d", i), rx[i], VEC[i][7:0]);
    repeat (30) @(negedge clk);
    chk("R6", "trailing pulses", post_rises, 2);
    chk("R6", "ser_clk low after trailer", ser_clk, 0);

    // ---- R11: user mode ignores the stream ----
    snap = rises;
    in_data = 8'h55; in_valid = 1'b1;
    ok = 1'b0;
    for (int w = 0; w < 30; w++) begin @(negedge clk); if (in_ready) ok = 1'b1; end
    in_valid = 1'b0;
    chk("R11", "in_ready in user mode", ok, 0);
    chk("R11", "no edges in user mode", rises, snap);
    chk("R11", "still done", done, 1);

    // ---- R3/R10: restart from user, status never rises ----
    st_delay = -1;
    last_low = 0;
    pulse_start();
    chk("R10", "restart from user drives prog_n low", prog_n, 0);
    wait_end(300);
    chk("R3", "status timeout flagged", error, 1);
    chk("R3", "status timeout code", err_code, 1);
    chk("R2", "prog_n low length on restart", last_low, RST_CYC);
    chk("R3", "no edges without status", early, 0);

    // ---- R8/R10: status drops mid-load ----
    st_delay = 5; total = NVEC; drop = 3;
    pulse_start();
    chk("R10", "error cleared by start", error, 0);
    chk("R10", "code cleared by start", err_code, 0);
    for (int i = 0; i < 6; i++) begin
      send_byte(VEC[i][7:0], ok);
      if (!ok) break;
    end
    wait_end(200);
    chk("R8", "abort flagged", error, 1);
    chk("R8", "abort code", err_code, 2);
    chk("R8", "ser_clk parked", ser_clk, 0);
    chk("R8", "in_ready dropped", in_ready, 0);
    chk("R8", "prog_n high", prog_n, 1);

    // ---- R9: byte limit without completion ----
    st_delay = 5; total = 100; drop = -1;
    pulse_start();
    for (int i = 0; i < MAXB; i++) begin
      send_byte(8'(i * 17 + 3), ok);
      chk("R9", $sformatf("byte %0d below limit accepted", i), ok, 1);
    end
    send_byte(8'hEE, ok);
    chk("R9", "byte over limit refused", ok, 0);
    wait_end(300);
    chk("R9", "completion timeout flagged", error, 1);
    chk("R9", "completion timeout code", err_code, 3);
    chk("R9", "bits delivered", bits, MAXB * 8);

    // ---- R7: init-done never arrives ----
    st_delay = 5; total = NVEC; init_delay = -1;
    pulse_start();
    for (int i = 0; i < NVEC; i++) send_byte(VEC[i][7:0], ok);
    wait_end(1000);
    chk("R7", "init timeout flagged", error, 1);
    chk("R7", "init timeout code", err_code, 4);
    chk("R7", "not done", done, 0);
    chk("R6", "trailing pulses before init wait", post_rises, 2);

    summary();
    $finish;
  end
endmodule